// File: doc/BRIEF.md
# Sequenced Accumulator Adder with Result Flags

This block is a small arithmetic datapath built around two operand registers: an operand register that holds the second addend and an accumulator that holds the first addend and later the result. A shared adder/subtractor uses two's complement arithmetic. Two strobes drive the block. A load strobe places the word on the memory data bus into the operand register. Transfer strobes go to the accumulator. An internal source-select flip-flop decides what each transfer writes. The first transfer after a load or a reset copies the memory word into the accumulator. The next transfer writes the adder/subtractor result back into the accumulator.

So one load followed by two transfers performs three steps in order: fill the operand, fill the accumulator, then sum into the accumulator. Sign, zero and carry flags are captured only on the transfer that writes a result. Both strobes are ordinary level inputs. They are sampled on the system clock, and only a low-to-high change acts.

Top module: `accum_seq_adder`

## Requirements
- R1: A synchronous active-high reset clears the accumulator, the operand register, all three flags and the source selector, so the first transfer after reset loads memory data.
- R2: On a clock edge where the load strobe is newly high, the operand register takes the memory data word and the source selector is cleared. The accumulator and the flags keep their values.
- R3: A transfer edge that arrives while the selector is clear copies the memory data word into the accumulator and leaves all three flags unchanged.
- R4: A transfer edge that arrives while the selector is set writes a result into the accumulator. With the subtract control at 0 the result is the accumulator plus the operand. With the subtract control at 1 it is the accumulator plus the inverted operand plus 1. In both cases only the low WIDTH bits are kept.
- R5: On a result write, the carry flag takes the carry out of the most significant adder stage. In subtract mode this carry is 1 when no borrow occurs.
- R6: On a result write, the sign flag takes the result's most significant bit. The zero flag is set only when every result bit is 0. The flags do not change at any other time.
- R7: Every transfer edge toggles the selector, even when no load came before it. After a load, the third transfer therefore loads memory data again.
- R8: Each strobe acts once per rise, on the first clock edge that sees it high, and the effect shows on the outputs after that edge. Holding a strobe high for more clock cycles has no further effect.
- R9: When the load and transfer strobes rise on the same edge, the transfer acts according to the selector value before that edge and uses the operand held before that edge. The operand register takes the memory word, and the selector ends clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| loadStb | input | 1 | Load strobe; its rise fills the operand register |
| xferStb | input | 1 | Transfer strobe; its rise writes the accumulator |
| subMode | input | 1 | 1 selects subtraction, 0 selects addition |
| memData | input | WIDTH | Memory data word |
| accA | output | WIDTH | Accumulator contents |
| regB | output | WIDTH | Operand register contents |
| flagSign | output | 1 | Sign flag |
| flagZero | output | 1 | Zero flag |
| flagCarry | output | 1 | Carry flag |

## Verification
Directed sums are chosen to separate the flags from each other:
- a result that sets the sign without a carry;
- a wrap to zero that sets both zero and carry;
- an equal-operand subtraction that gives zero with no borrow;
- a subtraction that borrows;
- a subtraction of zero.

Further directed cases cover the strobe sequencing:
- A strobe held high across several cycles shows that edge detection is in place.
- Transfers issued with no load before them show that the selector toggles on its own.
- A load rising together with a transfer shows which operand and selector value are used.

Random sequences of loads, transfers, coincident strobes and idle gaps, with random data and random subtract control, are compared with a reference model step by step.

// File: rtl/accum_pkg.sv
package accum_pkg;

  localparam int unsigned DefaultWidth = 4;

  // Strobes from the sequencing control to the datapath, valid for one clock.
  typedef struct packed {
    logic captureB;     // fill operand register from memory
    logic captureMem;   // fill accumulator from memory
    logic captureSum;   // fill accumulator from adder, update flags
  } ctrlStrobes_t;

endpackage

// File: rtl/accum_ctrl.sv
module accum_ctrl
  import accum_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         loadStb,
  input  logic         xferStb,
  output ctrlStrobes_t strobes
);

  logic loadPrev;
  logic xferPrev;
  logic srcSel;
  logic loadEdge;
  logic xferEdge;

  assign loadEdge = loadStb & ~loadPrev;
  assign xferEdge = xferStb & ~xferPrev;

  always_ff @(posedge clk) begin
    if (rst) begin
      loadPrev <= 1'b0;
      xferPrev <= 1'b0;
    end else begin
      loadPrev <= loadStb;
      xferPrev <= xferStb;
    end
  end

  // Source selector: cleared by load, toggled by each transfer.
  always_ff @(posedge clk) begin
    if (rst) begin
      srcSel <= 1'b0;
    end else if (loadEdge) begin
      srcSel <= 1'b0;
    end else if (xferEdge) begin
      srcSel <= ~srcSel;
    end
  end

  always_comb begin
    strobes.captureB   = loadEdge;
    strobes.captureMem = xferEdge & ~srcSel;
    strobes.captureSum = xferEdge & srcSel;
  end

endmodule

// File: rtl/accum_datapath.sv
module accum_datapath
  import accum_pkg::*;
#(
  parameter int unsigned WIDTH = DefaultWidth
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrlStrobes_t     strobes,
  input  logic             subMode,
  input  logic [WIDTH-1:0] memData,
  output logic [WIDTH-1:0] accA,
  output logic [WIDTH-1:0] regB,
  output logic             flagSign,
  output logic             flagZero,
  output logic             flagCarry
);

  localparam int unsigned MsbIdx = WIDTH - 1;

  logic [WIDTH-1:0] bOperand;
  logic [WIDTH-1:0] sumBits;
  logic [WIDTH:0]   carryChain;

  // Two's complement: invert operand and inject carry in subtract mode.
  assign bOperand      = regB ^ {WIDTH{subMode}};
  assign carryChain[0] = subMode;

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    assign sumBits[i]      = accA[i] ^ bOperand[i] ^ carryChain[i];
    assign carryChain[i+1] = (accA[i] & bOperand[i])
                           | (carryChain[i] & (accA[i] ^ bOperand[i]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      regB <= '0;
    end else if (strobes.captureB) begin
      regB <= memData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      accA <= '0;
    end else if (strobes.captureMem) begin
      accA <= memData;
    end else if (strobes.captureSum) begin
      accA <= sumBits;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flagSign  <= 1'b0;
      flagZero  <= 1'b0;
      flagCarry <= 1'b0;
    end else if (strobes.captureSum) begin
      flagSign  <= sumBits[MsbIdx];
      flagZero  <= ~|sumBits;
      flagCarry <= carryChain[WIDTH];
    end
  end

endmodule

// File: rtl/accum_seq_adder.sv
module accum_seq_adder
  import accum_pkg::*;
#(
  parameter int unsigned WIDTH = DefaultWidth
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             loadStb,
  input  logic             xferStb,
  input  logic             subMode,
  input  logic [WIDTH-1:0] memData,
  output logic [WIDTH-1:0] accA,
  output logic [WIDTH-1:0] regB,
  output logic             flagSign,
  output logic             flagZero,
  output logic             flagCarry
);

  ctrlStrobes_t strobes;

  accum_ctrl ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .loadStb (loadStb),
    .xferStb (xferStb),
    .strobes (strobes)
  );

  accum_datapath #(.WIDTH(WIDTH)) dp_i (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .subMode   (subMode),
    .memData   (memData),
    .accA      (accA),
    .regB      (regB),
    .flagSign  (flagSign),
    .flagZero  (flagZero),
    .flagCarry (flagCarry)
  );

endmodule

// File: rtl/accum_seq_adder_chk.sv
module accum_seq_adder_chk #(
  parameter int unsigned WIDTH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             loadStb,
  input logic             xferStb,
  input logic             subMode,
  input logic [WIDTH-1:0] memData,
  input logic [WIDTH-1:0] accA,
  input logic [WIDTH-1:0] regB,
  input logic             flagSign,
  input logic             flagZero,
  input logic             flagCarry
);

  // Independent observation model of strobe history and selector.
  logic loadQ;
  logic xferQ;
  logic selM;
  logic rstQ;
  logic loadRise;
  logic xferRise;
  logic [WIDTH:0] expRes;

  assign loadRise = loadStb && !loadQ;
  assign xferRise = xferStb && !xferQ;
  assign expRes   = subMode ? ({1'b0, accA} + {1'b0, ~regB} + 1'b1)
                            : ({1'b0, accA} + {1'b0, regB});

  always_ff @(posedge clk) begin
    rstQ <= rst;
    if (rst) begin
      loadQ <= 1'b0;
      xferQ <= 1'b0;
      selM  <= 1'b0;
    end else begin
      loadQ <= loadStb;
      xferQ <= xferStb;
      if (loadRise)      selM <= 1'b0;
      else if (xferRise) selM <= !selM;
    end
  end

  // R1
  always_ff @(posedge clk) begin
    if (rstQ) begin
      reset_state_chk: assert (accA == '0 && regB == '0 && !flagSign && !flagZero && !flagCarry)
        else $error("reset state not cleared");
    end
  end

  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (rst)
    loadRise |=> regB == $past(memData));

  // R3
  mem_to_acc_chk: assert property (@(posedge clk) disable iff (rst)
    (xferRise && !selM) |=> accA == $past(memData));

  // R4 R5
  sum_write_chk: assert property (@(posedge clk) disable iff (rst)
    (xferRise && selM) |=> {flagCarry, accA} == $past(expRes));

  // R6
  flag_value_chk: assert property (@(posedge clk) disable iff (rst)
    (xferRise && selM) |=> (flagZero == (accA == '0)) && (flagSign == accA[WIDTH-1]));

  // R6
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(xferRise && selM) |=> $stable(flagSign) && $stable(flagZero) && $stable(flagCarry));

  // R8
  no_edge_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!loadRise && !xferRise) |=> $stable(accA) && $stable(regB));

endmodule

bind accum_seq_adder accum_seq_adder_chk #(.WIDTH(WIDTH)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .loadStb   (loadStb),
  .xferStb   (xferStb),
  .subMode   (subMode),
  .memData   (memData),
  .accA      (accA),
  .regB      (regB),
  .flagSign  (flagSign),
  .flagZero  (flagZero),
  .flagCarry (flagCarry)
);

// File: tb/accum_seq_adder_tb_top.sv
module accum_seq_adder_tb_top;

  localparam int unsigned W = 4;

  logic         clk = 1'b0;
  logic         rst;
  logic         loadStb;
  logic         xferStb;
  logic         subMode;
  logic [W-1:0] memData;
  logic [W-1:0] accA;
  logic [W-1:0] regB;
  logic         flagSign;
  logic         flagZero;
  logic         flagCarry;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  // Reference model state.
  logic [W-1:0] mA;
  logic [W-1:0] mB;
  logic         mSel;
  logic         mS;
  logic         mZ;
  logic         mC;

  always #2 clk = ~clk;

  accum_seq_adder #(.WIDTH(W)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .loadStb   (loadStb),
    .xferStb   (xferStb),
    .subMode   (subMode),
    .memData   (memData),
    .accA      (accA),
    .regB      (regB),
    .flagSign  (flagSign),
    .flagZero  (flagZero),
    .flagCarry (flagCarry)
  );

  function automatic logic [W:0] refResult(logic [W-1:0] a, logic [W-1:0] b, logic sub);
    if (sub) return {1'b0, a} + {1'b0, ~b} + 1'b1;
    return {1'b0, a} + {1'b0, b};
  endfunction

  task automatic cmp(string tag, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic checkAll(string tag);
    cmp(tag, "accA", accA, mA);
    cmp(tag, "regB", regB, mB);
    cmp(tag, "flagSign", flagSign, mS);
    cmp(tag, "flagZero", flagZero, mZ);
    cmp(tag, "flagCarry", flagCarry, mC);
  endtask

  // Model update for one edge carrying the given strobe rises.
  task automatic modelEdge(bit ld, bit xf, logic [W-1:0] d, logic sub);
    logic [W:0] r;
    if (xf) begin
      if (!mSel) begin
        mA = d;
      end else begin
        r  = refResult(mA, mB, sub);
        mA = r[W-1:0];
        mC = r[W];
        mS = r[W-1];
        mZ = (r[W-1:0] == '0);
      end
    end
    if (ld) mB = d;
    if (ld) mSel = 1'b0;
    else if (xf) mSel = !mSel;
  endtask

  // One strobe step: raise, pass one edge, check, drop, idle one edge.
  task automatic step(bit ld, bit xf, logic [W-1:0] d, logic sub, string tag);
    loadStb = ld;
    xferStb = xf;
    memData = d;
    subMode = sub;
    @(negedge clk);
    modelEdge(ld, xf, d, sub);
    checkAll(tag);
    loadStb = 1'b0;
    xferStb = 1'b0;
    memData = ~d;
    subMode = ~sub;
    @(negedge clk);
    checkAll(tag);
  endtask

  task automatic doReset();
    rst = 1'b1;
    loadStb = 1'b0;
    xferStb = 1'b0;
    subMode = 1'b0;
    memData = '1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    mA = '0; mB = '0; mSel = 1'b0; mS = 1'b0; mZ = 1'b0; mC = 1'b0;
  endtask

  task automatic sumCase(logic [W-1:0] a, logic [W-1:0] b, logic sub, string tag);
    step(1'b1, 1'b0, b, 1'b0, "R2");
    step(1'b0, 1'b1, a, 1'b0, "R3");
    step(1'b0, 1'b1, 4'h0, sub, tag);
  endtask

  initial begin
    void'($urandom(32'd1357));
    doReset();
    @(negedge clk);
    checkAll("R1");
    // first transfer after reset takes memory data
    step(1'b0, 1'b1, 4'h9, 1'b0, "R1");

    // Directed corner sums
    sumCase(4'd7, 4'd1, 1'b0, "R6_sign_no_carry");
    sumCase(4'd15, 4'd1, 1'b0, "R5_R6_wrap_zero");
    sumCase(4'd5, 4'd5, 1'b1, "R4_R5_sub_equal");
    sumCase(4'd3, 4'd5, 1'b1, "R4_R5_sub_borrow");
    sumCase(4'd6, 4'd0, 1'b1, "R5_sub_zero");
    sumCase(4'd9, 4'd4, 1'b0, "R4_add");

    // R7: transfers with no load toggle the selector
    step(1'b0, 1'b1, 4'hA, 1'b0, "R7");
    step(1'b0, 1'b1, 4'h0, 1'b0, "R7");
    step(1'b0, 1'b1, 4'h3, 1'b0, "R7");
    step(1'b0, 1'b1, 4'h0, 1'b1, "R7");

    // R8: strobe held high acts once
    loadStb = 1'b1; memData = 4'hC;
    @(negedge clk);
    modelEdge(1'b1, 1'b0, 4'hC, 1'b0);
    memData = 4'h2;
    @(negedge clk);
    @(negedge clk);
    checkAll("R8_load_held");
    loadStb = 1'b0;
    xferStb = 1'b1; memData = 4'h5;
    @(negedge clk);
    modelEdge(1'b0, 1'b1, 4'h5, 1'b0);
    memData = 4'hE;
    @(negedge clk);
    @(negedge clk);
    checkAll("R8_xfer_held");
    xferStb = 1'b0;
    @(negedge clk);

    // R9: coincident strobes with the selector clear and set
    step(1'b1, 1'b1, 4'h4, 1'b0, "R9_sel_clear");
    step(1'b0, 1'b1, 4'h6, 1'b0, "R9");
    step(1'b1, 1'b1, 4'hB, 1'b0, "R9_sel_set");
    step(1'b0, 1'b1, 4'h1, 1'b0, "R9_after");

    // Random sequences
    for (int i = 0; i < 400; i++) begin
      int unsigned op;
      logic [W-1:0] d;
      logic sb;
      op = $urandom_range(0, 9);
      d  = W'($urandom);
      sb = 1'($urandom);
      if (op < 3)      step(1'b1, 1'b0, d, sb, "R2_rand");
      else if (op < 8) step(1'b0, 1'b1, d, sb, "R4_rand");
      else if (op < 9) step(1'b1, 1'b1, d, sb, "R9_rand");
      else             step(1'b0, 1'b0, d, sb, "R8_idle");
    end

    // R1: reset mid-sequence clears everything
    step(1'b1, 1'b0, 4'h7, 1'b0, "R2");
    doReset();
    @(negedge clk);
    checkAll("R1_again");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule